// File: doc/BRIEF.md
# IDE Channel Hidden Timing Configuration Window

This block decodes slave accesses to the eight-byte command-block range of one IDE channel. In normal operation every read or write is forwarded to the drive port, registered one cycle later. A short key sequence on the same offsets opens a private configuration window. While the window is open, accesses no longer reach the drive. Instead they reach a small register set: read-cycle timing, write-cycle timing, a control byte, a misc byte and a read-only clock strap.

Two timing banks exist, one for each drive on the cable. Software chooses which bank its timing writes land in, enables per-drive bank use, and then closes the window with a second key. The block always presents, as registered outputs, the read and write timing bytes for the drive that is currently selected. Strobe generation for the drive is done by a separate block that consumes these bytes.

Top module: `ide_cfg_window`

## Requirements
- R1: After synchronous reset the window is closed, `bus_rdata` is 0x00, no forwarded strobe is active, and both banks and both timing outputs hold 0x5B.
- R2: The window opens in the cycle after this exact sequence of accesses: a word read at offset 1, another word read at offset 1, then a byte write of 0x03 to offset 2. The accesses in this sequence are still forwarded to the drive.
- R3: While the window is closed, any access other than the expected next step of the key sequence returns the detector to its start. A third word read also counts as such an access. Cycles with no access leave the detector unchanged.
- R4: While the window is closed, each access appears on `dev_rd`/`dev_wr` one cycle later, with its address, size and data. While the window is open, no access is forwarded.
- R5: A byte write of 0x83 to offset 2 while the window is open closes it. That write is not forwarded.
- R6: A read while the window is open returns the addressed register on `bus_rdata` one cycle later. The map is: offset 0 is read timing, offset 1 is write timing (both in the addressed bank), offset 3 is control, and offset 6 is misc. Offsets 2, 4 and 7 read 0x00. In any cycle with no open-window read, `bus_rdata` is 0x00 one cycle later.
- R7: Offset 5 reads {7'b0, strap}, where strap is `clk_strap` sampled one cycle earlier (1 = 25 MHz bus, 0 = 33 MHz bus). Writes to offset 5 are ignored.
- R8: Timing reads and writes use bank B only when misc bit 0 is 1 and bank-B access has been enabled. Bank-B access is enabled by a byte write of 0xC0 to offset 3 while the window is closed. Otherwise bank A is used.
- R9: When control bit 0 is 1 (for example after writing 0x85), the timing outputs use bank B while `drv_sel` is 1 and bank A while it is 0. When control bit 0 is 0, they always use bank A. The outputs lag register or `drv_sel` changes by one cycle.
- R10: Read-cycle and write-cycle timing are independent registers in each bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 3 | Offset within the command-block range |
| bus_wdata | input | 8 | Write data (low byte) |
| bus_rdata | output | 8 | Configuration read data, registered |
| drv_sel | input | 1 | Currently selected drive (0 or 1) |
| clk_strap | input | 1 | Bus clock strap pin |
| dev_rd | output | 1 | Forwarded read strobe to the drive port |
| dev_wr | output | 1 | Forwarded write strobe to the drive port |
| dev_addr | output | 3 | Forwarded offset |
| dev_word | output | 1 | Forwarded access size |
| dev_wdata | output | 8 | Forwarded write data |
| cfg_open | output | 1 | Configuration window is open |
| tim_rd | output | 8 | Read-cycle timing for the selected drive |
| tim_wr | output | 8 | Write-cycle timing for the selected drive |

## Verification
The hardest state to reach is a programmed bank B that actually drives the timing outputs. Getting there needs three things: a closed-window 0xC0 enable write, a completed key sequence, and a misc write that points at bank B. Then, after bank A has been given different values, a control write that turns on per-drive use, followed by toggling `drv_sel`. The stimulus also runs the same path once with the enable write left out, to show that bank-B writes fall into bank A. Broken key sequences are driven as well: idle gaps, a byte-sized read, a third word read, and a wrong key value.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;
  localparam int OFS_W = 3;

  localparam logic [OFS_W-1:0] OFS_RD_TIM = 3'd0;
  localparam logic [OFS_W-1:0] OFS_WR_TIM = 3'd1;
  localparam logic [OFS_W-1:0] OFS_KEY    = 3'd2;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 3'd3;
  localparam logic [OFS_W-1:0] OFS_STRAP  = 3'd5;
  localparam logic [OFS_W-1:0] OFS_MISC   = 3'd6;
  localparam logic [OFS_W-1:0] OFS_PROBE  = OFS_WR_TIM;

  localparam logic [7:0] KEY_OPEN  = 8'h03;
  localparam logic [7:0] KEY_CLOSE = 8'h83;
  localparam logic [7:0] KEY_BANKB = 8'hC0;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_TWO  = 2'd2
  } seq_e;
endpackage

// File: rtl/ide_cfg_unlock.sv
module ide_cfg_unlock
  import ide_cfg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic             wr,
  input  logic             word,
  input  logic [OFS_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic             open_o
);
  seq_e seq_q, seq_d;
  logic open_q, open_d;
  logic any_acc, probe_rd, key_open, key_close;

  assign any_acc   = rd | wr;
  assign probe_rd  = rd && !wr && word && (addr == OFS_PROBE);
  assign key_open  = wr && !rd && !word && (addr == OFS_KEY) && (wdata == DW'(KEY_OPEN));
  assign key_close = wr && !rd && !word && (addr == OFS_KEY) && (wdata == DW'(KEY_CLOSE));

  always_comb begin
    seq_d  = seq_q;
    open_d = open_q;
    if (open_q) begin
      seq_d = SEQ_IDLE;
      if (key_close) open_d = 1'b0;
    end else if (any_acc) begin
      unique case (seq_q)
        SEQ_IDLE: seq_d = probe_rd ? SEQ_ONE : SEQ_IDLE;
        SEQ_ONE:  seq_d = probe_rd ? SEQ_TWO : SEQ_IDLE;
        SEQ_TWO: begin
          seq_d  = SEQ_IDLE;
          open_d = key_open;
        end
        default:  seq_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q  <= SEQ_IDLE;
      open_q <= 1'b0;
    end else begin
      seq_q  <= seq_d;
      open_q <= open_d;
    end
  end

  assign open_o = open_q;
endmodule

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
  import ide_cfg_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          NBANK   = 2,
  parameter logic [DW-1:0] RST_TIM = 8'h5B
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       open_i,
  input  logic                       rd,
  input  logic                       wr,
  input  logic                       word,
  input  logic [OFS_W-1:0]           addr,
  input  logic [DW-1:0]              wdata,
  input  logic                       strap_i,
  output logic [DW-1:0]              rdata_o,
  output logic                       per_drive_o,
  output logic [NBANK-1:0][DW-1:0]   rd_tim_o,
  output logic [NBANK-1:0][DW-1:0]   wr_tim_o
);
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic [DW-1:0] ctrl_q, misc_q, rdata_q;
  logic          strap_q, bankb_en_q;
  logic          cfg_wr, cfg_rd, bankb_key;
  logic [BW-1:0] acc_bank;
  logic [DW-1:0] rd_mux;

  assign cfg_wr    = open_i && wr && !rd;
  assign cfg_rd    = open_i && rd && !wr;
  assign bankb_key = !open_i && wr && !rd && !word && (addr == OFS_CTRL) &&
                     (wdata == DW'(KEY_BANKB));
  assign acc_bank  = bankb_en_q ? misc_q[BW-1:0] : '0;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] rt_q, wt_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        rt_q <= RST_TIM;
        wt_q <= RST_TIM;
      end else if (cfg_wr && (acc_bank == BW'(b))) begin
        if (addr == OFS_RD_TIM) rt_q <= wdata;
        if (addr == OFS_WR_TIM) wt_q <= wdata;
      end
    end
    assign rd_tim_o[b] = rt_q;
    assign wr_tim_o[b] = wt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      misc_q     <= '0;
      strap_q    <= 1'b0;
      bankb_en_q <= 1'b0;
    end else begin
      strap_q <= strap_i;
      if (bankb_key) bankb_en_q <= 1'b1;
      if (cfg_wr && addr == OFS_CTRL) ctrl_q <= wdata;
      if (cfg_wr && addr == OFS_MISC) misc_q <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      OFS_RD_TIM: rd_mux = rd_tim_o[acc_bank];
      OFS_WR_TIM: rd_mux = wr_tim_o[acc_bank];
      OFS_CTRL:   rd_mux = ctrl_q;
      OFS_STRAP:  rd_mux = {{(DW-1){1'b0}}, strap_q};
      OFS_MISC:   rd_mux = misc_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= cfg_rd ? rd_mux : '0;
  end

  assign rdata_o     = rdata_q;
  assign per_drive_o = ctrl_q[0];
endmodule

// File: rtl/ide_cfg_timing.sv
module ide_cfg_timing #(
  parameter int            DW      = 8,
  parameter int            NBANK   = 2,
  parameter logic [DW-1:0] RST_TIM = 8'h5B
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     per_drive,
  input  logic                     drv_sel,
  input  logic [NBANK-1:0][DW-1:0] rd_tim_i,
  input  logic [NBANK-1:0][DW-1:0] wr_tim_i,
  output logic [DW-1:0]            tim_rd_o,
  output logic [DW-1:0]            tim_wr_o
);
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic [BW-1:0] use_bank;
  assign use_bank = (per_drive && drv_sel && NBANK > 1) ? BW'(1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      tim_rd_o <= RST_TIM;
      tim_wr_o <= RST_TIM;
    end else begin
      tim_rd_o <= rd_tim_i[use_bank];
      tim_wr_o <= wr_tim_i[use_bank];
    end
  end
endmodule

// File: rtl/ide_cfg_window.sv
module ide_cfg_window
  import ide_cfg_pkg::*;
#(
  parameter int            DW      = 8,
  parameter int            NBANK   = 2,
  parameter logic [DW-1:0] RST_TIM = 8'h5B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic             bus_word,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             drv_sel,
  input  logic             clk_strap,
  output logic             dev_rd,
  output logic             dev_wr,
  output logic [OFS_W-1:0] dev_addr,
  output logic             dev_word,
  output logic [DW-1:0]    dev_wdata,
  output logic             cfg_open,
  output logic [DW-1:0]    tim_rd,
  output logic [DW-1:0]    tim_wr
);
  logic                     open_w, per_drive_w;
  logic [NBANK-1:0][DW-1:0] rd_tim_w, wr_tim_w;

  ide_cfg_unlock #(.DW(DW)) u_unlock (
    .clk(clk), .rst(rst), .rd(bus_rd), .wr(bus_wr), .word(bus_word),
    .addr(bus_addr), .wdata(bus_wdata), .open_o(open_w)
  );

  ide_cfg_regs #(.DW(DW), .NBANK(NBANK), .RST_TIM(RST_TIM)) u_regs (
    .clk(clk), .rst(rst), .open_i(open_w), .rd(bus_rd), .wr(bus_wr),
    .word(bus_word), .addr(bus_addr), .wdata(bus_wdata), .strap_i(clk_strap),
    .rdata_o(bus_rdata), .per_drive_o(per_drive_w),
    .rd_tim_o(rd_tim_w), .wr_tim_o(wr_tim_w)
  );

  ide_cfg_timing #(.DW(DW), .NBANK(NBANK), .RST_TIM(RST_TIM)) u_timing (
    .clk(clk), .rst(rst), .per_drive(per_drive_w), .drv_sel(drv_sel),
    .rd_tim_i(rd_tim_w), .wr_tim_i(wr_tim_w),
    .tim_rd_o(tim_rd), .tim_wr_o(tim_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_rd    <= 1'b0;
      dev_wr    <= 1'b0;
      dev_addr  <= '0;
      dev_word  <= 1'b0;
      dev_wdata <= '0;
    end else begin
      dev_rd    <= bus_rd && !open_w;
      dev_wr    <= bus_wr && !open_w;
      dev_addr  <= bus_addr;
      dev_word  <= bus_word;
      dev_wdata <= bus_wdata;
    end
  end

  assign cfg_open = open_w;
endmodule

// File: rtl/ide_cfg_window_chk.sv
module ide_cfg_window_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_word,
  input logic [2:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          dev_rd,
  input logic          dev_wr,
  input logic          cfg_open
);
  a_r4_closed_read_forwarded: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !cfg_open) |=> dev_rd);

  a_r4_open_not_forwarded: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && (bus_rd || bus_wr)) |=> (!dev_rd && !dev_wr));

  a_r5_close_key: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && bus_wr && !bus_rd && !bus_word && bus_addr == 3'd2 &&
     bus_wdata == DW'(8'h83)) |=> !cfg_open);

  a_r2_open_after_key: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_open) |-> $past(bus_wr && !bus_word && bus_addr == 3'd2 &&
                              bus_wdata == DW'(8'h03)));

  a_r3_idle_keeps_window: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd && !bus_wr) |=> $stable(cfg_open));

  a_r7_strap_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && bus_rd && bus_addr == 3'd5) |=> (bus_rdata[DW-1:1] == '0));

  a_r6_no_read_zero: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && cfg_open) |=> (bus_rdata == '0));
endmodule

bind ide_cfg_window ide_cfg_window_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .dev_rd(dev_rd), .dev_wr(dev_wr), .cfg_open(cfg_open)
);

// File: tb/tb_ide_cfg_window.sv
module tb_ide_cfg_window;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rd = 0, bus_wr = 0, bus_word = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       drv_sel = 0, clk_strap = 0;
  logic       dev_rd, dev_wr, dev_word, cfg_open;
  logic [2:0] dev_addr;
  logic [7:0] dev_wdata, tim_rd, tim_wr;

  int vectors = 0;
  int fails = 0;
  string tag = "R1";

  // behavioural model state
  bit       m_open;
  int       m_step;
  bit [7:0] m_rt[2], m_wt[2], m_ctrl, m_misc;
  bit       m_ben, m_strap;
  bit [7:0] e_rdata, e_tim_rd, e_tim_wr;
  bit       e_dev_rd, e_dev_wr;

  always #5 clk = ~clk;

  ide_cfg_window dut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drv_sel(drv_sel), .clk_strap(clk_strap), .dev_rd(dev_rd), .dev_wr(dev_wr),
    .dev_addr(dev_addr), .dev_word(dev_word), .dev_wdata(dev_wdata),
    .cfg_open(cfg_open), .tim_rd(tim_rd), .tim_wr(tim_wr)
  );

  task automatic model_reset();
    m_open = 0; m_step = 0; m_ctrl = 0; m_misc = 0; m_ben = 0; m_strap = 0;
    for (int i = 0; i < 2; i++) begin m_rt[i] = 8'h5B; m_wt[i] = 8'h5B; end
    e_rdata = 0; e_tim_rd = 8'h5B; e_tim_wr = 8'h5B; e_dev_rd = 0; e_dev_wr = 0;
  endtask

  task automatic model_edge();
    int bank, tb;
    bit probe;
    bank = (m_ben && m_misc[0]) ? 1 : 0;
    tb   = (m_ctrl[0] && drv_sel) ? 1 : 0;
    e_tim_rd = m_rt[tb];
    e_tim_wr = m_wt[tb];
    e_dev_rd = bus_rd && !m_open;
    e_dev_wr = bus_wr && !m_open;
    e_rdata  = 0;
    if (m_open && bus_rd) begin
      case (bus_addr)
        0: e_rdata = m_rt[bank];
        1: e_rdata = m_wt[bank];
        3: e_rdata = m_ctrl;
        5: e_rdata = {7'b0, m_strap};
        6: e_rdata = m_misc;
        default: e_rdata = 0;
      endcase
    end
    m_strap = clk_strap;
    if (m_open) begin
      m_step = 0;
      if (bus_wr) begin
        case (bus_addr)
          0: m_rt[bank] = bus_wdata;
          1: m_wt[bank] = bus_wdata;
          3: m_ctrl = bus_wdata;
          6: m_misc = bus_wdata;
          2: if (!bus_word && bus_wdata == 8'h83) m_open = 0;
          default: ;
        endcase
      end
    end else if (bus_rd || bus_wr) begin
      if (bus_wr && !bus_word && bus_addr == 3 && bus_wdata == 8'hC0) m_ben = 1;
      probe = bus_rd && bus_word && bus_addr == 1;
      if (m_step == 2) begin
        m_open = bus_wr && !bus_word && bus_addr == 2 && bus_wdata == 8'h03;
        m_step = 0;
      end else m_step = probe ? m_step + 1 : 0;
    end
  endtask

  task automatic cmp(string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    cmp("rdata", bus_rdata, e_rdata);
    cmp("dev_rd", {7'b0, dev_rd}, {7'b0, e_dev_rd});
    cmp("dev_wr", {7'b0, dev_wr}, {7'b0, e_dev_wr});
    cmp("cfg_open", {7'b0, cfg_open}, {7'b0, m_open});
    cmp("tim_rd", tim_rd, e_tim_rd);
    cmp("tim_wr", tim_wr, e_tim_wr);
  endtask

  task automatic cyc(bit r, bit w, bit wd, bit [2:0] a, bit [7:0] d);
    @(negedge clk);
    bus_rd = r; bus_wr = w; bus_word = wd; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (rst) model_reset(); else model_edge();
    #1 compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    idle(2);
    @(negedge clk); rst = 0;
  endtask

  task automatic unlock();
    cyc(1, 0, 1, 1, 0); cyc(1, 0, 1, 1, 0); cyc(0, 1, 0, 2, 8'h03);
  endtask

  task automatic wcfg(bit [2:0] a, bit [7:0] d); cyc(0, 1, 0, a, d); endtask
  task automatic rcfg(bit [2:0] a); cyc(1, 0, 0, a, 0); endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    tag = "R1"; idle(1);
    cmp("R1 reset tim_rd", tim_rd, 8'h5B);
    cmp("R1 reset open", {7'b0, cfg_open}, 8'h00);

    tag = "R4"; cyc(1, 0, 1, 0, 0); cyc(0, 1, 0, 7, 8'hA5);
    cmp("R4 forwarded data", dev_wdata, 8'hA5);
    cmp("R4 forwarded addr", {5'b0, dev_addr}, 8'h07);
    tag = "R8"; wcfg(3, 8'hC0);

    tag = "R2"; unlock();
    cmp("R2 window open", {7'b0, cfg_open}, 8'h01);
    tag = "R6"; rcfg(0);
    cmp("R6 read timing reset", bus_rdata, 8'h5B);
    rcfg(2); rcfg(4); rcfg(7); rcfg(3); rcfg(6);

    tag = "R7"; clk_strap = 1; idle(1); rcfg(5);
    cmp("R7 strap 25MHz", bus_rdata, 8'h01);
    wcfg(5, 8'hFE); rcfg(5);
    cmp("R7 strap write ignored", bus_rdata, 8'h01);
    clk_strap = 0; idle(1); rcfg(5);
    cmp("R7 strap 33MHz", bus_rdata, 8'h00);

    tag = "R10"; wcfg(6, 8'h01); wcfg(0, 8'h21); wcfg(1, 8'h34);
    wcfg(6, 8'h00); wcfg(0, 8'h45); wcfg(1, 8'h32);
    rcfg(0); cmp("R10 bank A read timing", bus_rdata, 8'h45);
    rcfg(1); cmp("R10 bank A write timing", bus_rdata, 8'h32);
    tag = "R8"; wcfg(6, 8'h01); rcfg(0);
    cmp("R8 bank B read timing", bus_rdata, 8'h21);

    tag = "R9"; idle(2);
    cmp("R9 per-drive off", tim_rd, 8'h45);
    wcfg(3, 8'h85); drv_sel = 1; idle(2);
    cmp("R9 drive1 rd", tim_rd, 8'h21);
    cmp("R9 drive1 wr", tim_wr, 8'h34);
    drv_sel = 0; idle(2);
    cmp("R9 drive0 rd", tim_rd, 8'h45);
    drv_sel = 1; idle(1);

    tag = "R5"; cyc(0, 1, 0, 2, 8'h83);
    cmp("R5 close not forwarded", {7'b0, dev_wr}, 8'h00);
    cmp("R5 closed", {7'b0, cfg_open}, 8'h00);
    cyc(1, 0, 1, 0, 0);
    cmp("R5 pass-through resumed", {7'b0, dev_rd}, 8'h01);

    tag = "R3";
    cyc(1, 0, 1, 1, 0); idle(3); cyc(1, 0, 1, 1, 0); cyc(0, 1, 0, 2, 8'h03);
    cmp("R3 idle gap kept step", {7'b0, cfg_open}, 8'h01);
    cyc(0, 1, 0, 2, 8'h83);
    cyc(1, 0, 1, 1, 0); cyc(1, 0, 0, 1, 0); cyc(1, 0, 1, 1, 0); cyc(0, 1, 0, 2, 8'h03);
    cmp("R3 byte read breaks", {7'b0, cfg_open}, 8'h00);
    cyc(1, 0, 1, 1, 0); cyc(1, 0, 1, 1, 0); cyc(1, 0, 1, 1, 0); cyc(0, 1, 0, 2, 8'h03);
    cmp("R3 third read breaks", {7'b0, cfg_open}, 8'h00);
    cyc(1, 0, 1, 1, 0); cyc(1, 0, 1, 1, 0); cyc(0, 1, 0, 2, 8'h04);
    cmp("R3 wrong key", {7'b0, cfg_open}, 8'h00);
    cyc(1, 0, 1, 1, 0); cyc(1, 0, 1, 1, 0); cyc(0, 1, 1, 2, 8'h03);
    cmp("R3 word key", {7'b0, cfg_open}, 8'h00);

    tag = "R8"; do_reset(); drv_sel = 1;
    unlock(); wcfg(6, 8'h01); wcfg(0, 8'h10); wcfg(3, 8'h85); idle(2);
    cmp("R8 drive1 bank B untouched", tim_rd, 8'h5B);
    rcfg(0); cmp("R8 write fell to bank A", bus_rdata, 8'h10);
    drv_sel = 0; idle(2);
    cmp("R8 drive0 bank A", tim_rd, 8'h10);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule